// File: doc/BRIEF.md
# Reset and Power Mode Controller

This block gathers the reset causes of a chip and turns them into clean reset outputs for two domains: the high-speed system bus (processor, bus controller, memory controller, DMA, arbiter, address decoder) and the slower peripheral bus. A cold reset comes from the power-on input or from the loss of a stable clock. It clears every domain and also keeps every shared bus driver disabled. A warm reset is requested by the watchdog overflow, by the watchdog manual reset or by software. It holds only the system-bus domain for a fixed, parameterised number of bus clocks. The peripheral domain keeps running through it.

The controller also keeps the operating mode: in reset, run with the standard bus clock, run with the fast bus clock, or power-down. It holds one clock-enable mask bit for each system-bus device and each peripheral. The enables leave the block as registered signals, so clock gates further down can use them without glitches. In power-down every enable is forced off. A small write port sets the mode and the masks. A one-hot cause field records what caused the latest reset.

Top module: `rst_pwr_ctrl`

## Requirements
- R1: The cause output is one-hot with bit0 = power-on, bit1 = watchdog overflow, bit2 = watchdog manual reset, bit3 = software request. When several warm requests arrive in the same cycle, overflow wins over manual, and manual wins over software.
- R2: A low por_n_i or a low clk_stable_i asserts per_rst_n_o and sys_rst_n_o at once, without waiting for a clock. Once both inputs are high before a rising edge E0, per_rst_n_o goes high after edge E1 and sys_rst_n_o goes high after edge E3.
- R3: bus_oe_en_o is low whenever the cold reset is active. This includes the whole time por_n_i is low.
- R4: A warm request sampled at edge E0 drives sys_rst_n_o low right after E0. The output stays low until edge E0+WARM_CYC+2, so the low time is WARM_CYC+2 cycles.
- R5: A warm reset leaves per_rst_n_o high, bus_oe_en_o high and both clock masks unchanged.
- R6: mode_o encodes 0 = in reset, 1 = standard run, 2 = fast run, 3 = power-down. It reads 0 while sys_rst_n_o is low and reads 1 after any reset is released.
- R7: A write to address 0 loads the mode from wr_data_i[1:0] when that value is 1, 2 or 3. A value of 0 is ignored. In power-down every clock enable is 0. Leaving power-down brings back the masked enables.
- R8: A write to address 1 loads the system mask from wr_data_i[NSYS-1:0]. A write to address 2 loads the peripheral mask from wr_data_i[NPER-1:0]. Mask bit i set to 1 enables device i. A write to address 3 has no effect.
- R9: After a cold reset both masks are all ones and the mode is standard run.
- R10: A warm request that arrives while a warm reset is running restarts the count. sys_rst_n_o then goes high WARM_CYC+2 edges after the last request.
- R11: The cause is set to power-on only by a cold reset. Each warm request replaces it, and register writes never change it.
- R12: A write sampled at edge E shows on mode_o and on the enables right after E. Writes are ignored while sys_rst_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| clk_stable_i | input | 1 | High when the bus clock is safe and stable |
| wdt_ovf_i | input | 1 | Watchdog overflow reset request |
| wdt_man_i | input | 1 | Watchdog manual reset request |
| sw_rst_i | input | 1 | Software reset request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mode, 1 system mask, 2 peripheral mask |
| wr_data_i | input | DW | Register write data |
| sys_rst_n_o | output | 1 | System-bus domain reset, active low |
| per_rst_n_o | output | 1 | Peripheral domain reset (cold only), active low |
| bus_oe_en_o | output | 1 | Permission for shared bus drivers to enable |
| mode_o | output | 2 | Operating mode |
| sys_clk_en_o | output | NSYS | Registered system-bus clock enables |
| per_clk_en_o | output | NPER | Registered peripheral clock enables |
| cause_o | output | 4 | One-hot cause of the latest reset |

## Verification
Every result has a fixed edge count. Register writes show one edge after they are sampled. A warm request holds sys_rst_n_o low for WARM_CYC+2 edges counted from the last request. A cold release frees the peripheral domain two edges after the inputs rise and the system domain four edges after. The bench drives on falling edges and samples on the next falling edge, so each check falls in the cycle the counting gives. The asynchronous assertion of reset is checked a few nanoseconds after por_n_i or clk_stable_i drops, before any clock edge.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [1:0] {
        MODE_RESET = 2'd0,
        MODE_STD   = 2'd1,
        MODE_FAST  = 2'd2,
        MODE_PDOWN = 2'd3
    } mode_e;

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_POR = 4'b0001;
    localparam logic [CAUSE_W-1:0] CAUSE_OVF = 4'b0010;
    localparam logic [CAUSE_W-1:0] CAUSE_MAN = 4'b0100;
    localparam logic [CAUSE_W-1:0] CAUSE_SW  = 4'b1000;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_SYSM = 2'd1;
    localparam logic [1:0] ADDR_PERM = 2'd2;
endpackage

// File: rtl/rpc_rst_sync.sv
module rpc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rpc_warm_seq.sv
module rpc_warm_seq
    import rpc_pkg::*;
#(
    parameter int WARM_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wdt_ovf_i,
    input  logic               wdt_man_i,
    input  logic               sw_req_i,
    output logic               idle_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int CW = $clog2(WARM_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(WARM_CYC);

    typedef struct packed {
        logic [CW-1:0]      cnt;
        logic               idle;
        logic [CAUSE_W-1:0] cause;
    } seq_t;

    seq_t seq_d, seq_q;
    logic req;

    always_comb begin
        req   = wdt_ovf_i | wdt_man_i | sw_req_i;
        seq_d = seq_q;
        if (req) begin
            seq_d.cnt  = CNT_LOAD;
            seq_d.idle = 1'b0;
            if (wdt_ovf_i)      seq_d.cause = CAUSE_OVF;
            else if (wdt_man_i) seq_d.cause = CAUSE_MAN;
            else                seq_d.cause = CAUSE_SW;
        end else if (seq_q.cnt != '0) begin
            seq_d.cnt  = seq_q.cnt - 1'b1;
            seq_d.idle = (seq_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{cnt: '0, idle: 1'b1, cause: CAUSE_POR};
        else        seq_q <= seq_d;
    end

    assign idle_o  = seq_q.idle;
    assign cause_o = seq_q.cause;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt <= CNT_LOAD);                                          // R4
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (seq_q.cnt == CNT_LOAD) && !idle_o);                     // R10
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause_o) == 1);                                       // R1
endmodule

// File: rtl/rpc_cfg_regs.sv
module rpc_cfg_regs
    import rpc_pkg::*;
#(
    parameter int NSYS = 6,
    parameter int NPER = 8,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sys_rst_n,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [1:0]      mode_o,
    output logic [NSYS-1:0] sys_en_o,
    output logic [NPER-1:0] per_en_o
);
    typedef struct packed {
        mode_e           mode;
        logic [NSYS-1:0] sys_mask;
        logic [NPER-1:0] per_mask;
        logic [NSYS-1:0] sys_en;
        logic [NPER-1:0] per_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!sys_rst_n) begin
            cfg_d.mode = MODE_STD;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_MODE: if (wr_data_i[1:0] != 2'd0) cfg_d.mode = mode_e'(wr_data_i[1:0]);
                ADDR_SYSM: cfg_d.sys_mask = wr_data_i[NSYS-1:0];
                ADDR_PERM: cfg_d.per_mask = wr_data_i[NPER-1:0];
                default:   ;
            endcase
        end
        if (cfg_d.mode == MODE_PDOWN) begin
            cfg_d.sys_en = '0;
            cfg_d.per_en = '0;
        end else begin
            cfg_d.sys_en = cfg_d.sys_mask;
            cfg_d.per_en = cfg_d.per_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{mode: MODE_STD, sys_mask: '1, per_mask: '1,
                               sys_en: '1, per_en: '1};
        else        cfg_q <= cfg_d;
    end

    assign mode_o   = cfg_q.mode;
    assign sys_en_o = cfg_q.sys_en;
    assign per_en_o = cfg_q.per_en;

    AST_PDOWN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_PDOWN) |-> (sys_en_o == '0 && per_en_o == '0)); // R7
    AST_NO_WR_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> $stable(cfg_q.sys_mask) && $stable(cfg_q.per_mask)); // R12
endmodule

// File: rtl/rst_pwr_ctrl.sv
module rst_pwr_ctrl
    import rpc_pkg::*;
#(
    parameter int NSYS     = 6,
    parameter int NPER     = 8,
    parameter int DW       = 16,
    parameter int WARM_CYC = 16
) (
    input  logic               clk,
    input  logic               por_n_i,
    input  logic               clk_stable_i,
    input  logic               wdt_ovf_i,
    input  logic               wdt_man_i,
    input  logic               sw_rst_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [DW-1:0]      wr_data_i,
    output logic               sys_rst_n_o,
    output logic               per_rst_n_o,
    output logic               bus_oe_en_o,
    output logic [1:0]         mode_o,
    output logic [NSYS-1:0]    sys_clk_en_o,
    output logic [NPER-1:0]    per_clk_en_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic cold_arst_n, cold_n, warm_idle, sys_arst_n;
    logic [1:0] mode_reg;

    assign cold_arst_n = por_n_i & clk_stable_i;

    rpc_rst_sync #(.STAGES(2)) u_cold_sync (
        .clk(clk), .arst_n(cold_arst_n), .rst_n(cold_n)
    );

    rpc_warm_seq #(.WARM_CYC(WARM_CYC)) u_warm (
        .clk(clk), .rst_n(cold_n),
        .wdt_ovf_i(wdt_ovf_i), .wdt_man_i(wdt_man_i), .sw_req_i(sw_rst_i),
        .idle_o(warm_idle), .cause_o(cause_o)
    );

    assign sys_arst_n = cold_n & warm_idle;

    rpc_rst_sync #(.STAGES(2)) u_sys_sync (
        .clk(clk), .arst_n(sys_arst_n), .rst_n(sys_rst_n_o)
    );

    rpc_cfg_regs #(.NSYS(NSYS), .NPER(NPER), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(cold_n), .sys_rst_n(sys_rst_n_o),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .mode_o(mode_reg), .sys_en_o(sys_clk_en_o), .per_en_o(per_clk_en_o)
    );

    assign per_rst_n_o = cold_n;
    assign bus_oe_en_o = cold_n;
    assign mode_o      = sys_rst_n_o ? mode_reg : MODE_RESET;

    AST_POR_OE: assert property (@(posedge clk) disable iff (!clk_stable_i)
        !por_n_i |-> (!bus_oe_en_o && !sys_rst_n_o));                    // R3
    AST_PER_KEPT: assert property (@(posedge clk) disable iff (!cold_arst_n)
        (!sys_rst_n_o && $past(per_rst_n_o)) |-> per_rst_n_o);           // R5
    AST_MODE_AFTER_RST: assert property (@(posedge clk) disable iff (!cold_n)
        $rose(sys_rst_n_o) |-> (mode_o == MODE_STD));                    // R6
endmodule

// File: tb/rst_pwr_ctrl_bench.sv
module rst_pwr_ctrl_bench;
    localparam int NSYS = 6;
    localparam int NPER = 8;
    localparam int DW = 16;
    localparam int WARM_CYC = 16;

    logic clk = 1'b0;
    logic por_n = 1'b0, clk_stable = 1'b0;
    logic wdt_ovf = 1'b0, wdt_man = 1'b0, sw_rst = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic sys_rst_n, per_rst_n, bus_oe_en;
    logic [1:0] mode;
    logic [NSYS-1:0] sys_en;
    logic [NPER-1:0] per_en;
    logic [3:0] cause;

    int tests = 0, fails = 0;
    logic [1:0] m_mode;
    logic [NSYS-1:0] m_sysm;
    logic [NPER-1:0] m_perm;
    logic [3:0] m_cause;

    always #10 clk = ~clk;

    rst_pwr_ctrl #(.NSYS(NSYS), .NPER(NPER), .DW(DW), .WARM_CYC(WARM_CYC)) u_rst_pwr_ctrl (
        .clk(clk), .por_n_i(por_n), .clk_stable_i(clk_stable),
        .wdt_ovf_i(wdt_ovf), .wdt_man_i(wdt_man), .sw_rst_i(sw_rst),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .sys_rst_n_o(sys_rst_n), .per_rst_n_o(per_rst_n), .bus_oe_en_o(bus_oe_en),
        .mode_o(mode), .sys_clk_en_o(sys_en), .per_clk_en_o(per_en), .cause_o(cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [NSYS-1:0] exp_sys(input logic [1:0] md, input logic [NSYS-1:0] mk);
        return (md == 2'd3) ? '0 : mk;
    endfunction

    function automatic logic [NPER-1:0] exp_per(input logic [1:0] md, input logic [NPER-1:0] mk);
        return (md == 2'd3) ? '0 : mk;
    endfunction

    task automatic model_cold();
        m_mode = 2'd1; m_sysm = '1; m_perm = '1; m_cause = 4'b0001;
    endtask

    task automatic check_run(input string tag);
        chk({tag, " R6 mode"}, 32'(mode), 32'(m_mode));
        chk({tag, " R7/R8 sys_en"}, 32'(sys_en), 32'(exp_sys(m_mode, m_sysm)));
        chk({tag, " R7/R8 per_en"}, 32'(per_en), 32'(exp_per(m_mode, m_perm)));
        chk({tag, " R11 cause"}, 32'(cause), 32'(m_cause));
        chk({tag, " R5 per_rst"}, 32'(per_rst_n), 32'd1);
        chk({tag, " R4 sys_rst"}, 32'(sys_rst_n), 32'd1);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: if (d[1:0] != 2'd0) m_mode = d[1:0];
            2'd1: m_sysm = d[NSYS-1:0];
            2'd2: m_perm = d[NPER-1:0];
            default: ;
        endcase
        check_run("R12 write");
    endtask

    // which: 0 ovf, 1 manual, 2 software, 3 ovf+man+sw together
    task automatic do_warm(input int which, input int restart_at);
        int last;
        last = (restart_at > 0) ? restart_at : 0;
        @(negedge clk);
        wdt_ovf = (which == 0 || which == 3);
        wdt_man = (which == 1 || which == 3);
        sw_rst  = (which == 2 || which == 3);
        case (which)
            0, 3: m_cause = 4'b0010;
            1: m_cause = 4'b0100;
            default: m_cause = 4'b1000;
        endcase
        for (int k = 1; k <= last + WARM_CYC + 3; k++) begin
            @(negedge clk);
            wdt_ovf = 1'b0; wdt_man = 1'b0;
            sw_rst = (k == restart_at);
            wr_en = (k == 3); wr_addr = 2'd1; wr_data = '0;
            if (k == restart_at) m_cause = 4'b1000;
            if (k == last + WARM_CYC + 3) begin
                chk("R4/R10 sys_rst released", 32'(sys_rst_n), 32'd1);
            end else begin
                chk("R4/R10 sys_rst held", 32'(sys_rst_n), 32'd0);
                chk("R6 mode in reset", 32'(mode), 32'd0);
            end
            chk("R5 per_rst kept", 32'(per_rst_n), 32'd1);
            chk("R5 bus_oe kept", 32'(bus_oe_en), 32'd1);
        end
        wr_en = 1'b0;
        m_mode = 2'd1;
        check_run("R5 after warm");
    endtask

    // use_stable: drop clk_stable instead of por
    task automatic do_cold(input bit use_stable);
        @(negedge clk);
        #3;
        if (use_stable) clk_stable = 1'b0; else por_n = 1'b0;
        #2;
        chk("R2 async per_rst", 32'(per_rst_n), 32'd0);
        chk("R2 async sys_rst", 32'(sys_rst_n), 32'd0);
        chk("R3 bus_oe off", 32'(bus_oe_en), 32'd0);
        chk("R6 mode reset", 32'(mode), 32'd0);
        repeat (3) @(negedge clk);
        chk("R3 bus_oe held", 32'(bus_oe_en), 32'd0);
        chk("R1 cause por", 32'(cause), 32'b0001);
        chk("R9 sys mask ones", 32'(sys_en), 32'(2**NSYS - 1));
        chk("R9 per mask ones", 32'(per_en), 32'(2**NPER - 1));
        por_n = 1'b1; clk_stable = 1'b1;
        @(negedge clk); chk("R2 per low N1", 32'(per_rst_n), 32'd0);
        @(negedge clk); chk("R2 per high N2", 32'(per_rst_n), 32'd1);
        chk("R3 bus_oe on", 32'(bus_oe_en), 32'd1);
        @(negedge clk); chk("R2 sys low N3", 32'(sys_rst_n), 32'd0);
        @(negedge clk); chk("R2 sys high N4", 32'(sys_rst_n), 32'd1);
        model_cold();
        check_run("R9 after cold");
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_cold();
        #35;
        chk("R2 reset per", 32'(per_rst_n), 32'd0);
        chk("R2 reset sys", 32'(sys_rst_n), 32'd0);
        chk("R3 reset bus_oe", 32'(bus_oe_en), 32'd0);
        chk("R6 reset mode", 32'(mode), 32'd0);
        clk_stable = 1'b1;
        @(negedge clk);
        chk("R3 por only bus_oe", 32'(bus_oe_en), 32'd0);
        por_n = 1'b1;
        @(negedge clk); chk("R2 first per low", 32'(per_rst_n), 32'd0);
        @(negedge clk); chk("R2 first per high", 32'(per_rst_n), 32'd1);
        @(negedge clk); chk("R2 first sys low", 32'(sys_rst_n), 32'd0);
        @(negedge clk); chk("R2 first sys high", 32'(sys_rst_n), 32'd1);
        check_run("R9 first release");

        do_write(2'd1, 16'h0015);
        do_write(2'd2, 16'h00A3);
        do_write(2'd3, 16'hFFFF);              // R8 ignored address
        do_write(2'd0, 16'h0000);              // R7 mode 0 ignored
        do_write(2'd0, 16'h0002);              // R7 fast
        do_write(2'd0, 16'h0003);              // R7 power-down
        do_write(2'd1, 16'h003C);              // R8 mask write in power-down
        do_write(2'd0, 16'h0001);              // R7 leave power-down
        do_write(2'd0, 16'h0003);
        do_warm(0, 0);                          // R1 overflow, leaves power-down
        do_warm(1, 0);                          // R1 manual
        do_warm(2, 0);                          // R1 software
        do_warm(3, 0);                          // R1 priority
        do_warm(0, 6);                          // R10 restart
        do_cold(1'b0);
        do_write(2'd2, 16'h0055);
        do_warm(2, 0);
        do_cold(1'b1);                          // R2 clock-stable loss

        for (int i = 0; i < 60; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 6) begin
                logic [1:0] a;
                logic [DW-1:0] d;
                a = 2'($urandom);
                d = DW'($urandom);
                do_write(a, d);
            end else begin
                do_warm(int'($urandom % 4), (r == 7) ? int'($urandom % 10) : 0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule